// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Controller

This block arbitrates interrupts among a short series chain of peripheral interrupt nodes. Each node has an enable input from the node above it and an enable output to the node below it, a local request line, and a programmable 8-bit vector. Node 0 sits at the head of the chain and has the highest priority. A node passes the enable downstream only while it is idle and its own enable input is high. The per-node request lines combine into one active-low interrupt output.

The block watches the processor's opcode-fetch strobe, its I/O strobe and the opcode data bus. When both strobes are high together, the cycle is an interrupt acknowledge. The winning node's vector goes out on the vector port, and that node moves from pending to under service. Service can nest. A higher-priority node may preempt a node that is already under service, and each two-byte return opcode ends only the service of the highest-priority active node. The preempted service then resumes, and a second return completes it.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, no node is pending or under service. With `iei_i` high, all `ieo_o` bits are high, `int_no` is high and `vec_oe_o` is low.
- R2: A node's enable output is low whenever its enable input is low. With `iei_i` low, every `ieo_o` bit is low, and no node holds `int_no` low.
- R3: A node whose `req_i` bit is high at a clock edge where `m1_i` is low becomes pending. A pending node drives its own `ieo_o` bit low. While its enable input is high, it also pulls `int_no` low.
- R4: An acknowledge is a cycle with `m1_i` and `iorq_i` both high. At the first edge of an acknowledge, the pending node whose enable input is high becomes under service and releases `int_no`. From the cycle after that edge until the acknowledge ends, `vec_o` carries that node's vector (bits 8k+7:8k of `vec_i` for node k) and `vec_oe_o` is high.
- R5: When several nodes are pending, the lowest-indexed one wins the acknowledge. At most one node is granted per acknowledge. A pending node below a node under service does not pull `int_no` low.
- R6: A node under service holds its `ieo_o` bit low. While that node is under service, a higher-priority node may still request and be acknowledged, and the lower node stays under service.
- R7: An opcode fetch is the first cycle of a run of `m1_i` high with `iorq_i` low. A return is a fetch of 0x4D whose previous fetch was 0xED. A fetch of any other byte after 0xED cancels the pair.
- R8: A return clears the under-service state only of the node that is under service with its enable input high. Suspended nodes ignore that return. They resume, and a second return clears them, after which all `ieo_o` bits go high.
- R9: A `req_i` that is high only while `m1_i` is high is not captured, so the pending state stays frozen during the opcode-fetch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m1_i | input | 1 | Opcode-fetch strobe, active high |
| iorq_i | input | 1 | I/O strobe, active high |
| data_i | input | 8 | Opcode bus |
| iei_i | input | 1 | Chain enable into node 0 |
| req_i | input | N_NODES | Per-node interrupt requests |
| vec_i | input | N_NODES*8 | Per-node vectors, node k at bits 8k+7:8k |
| ieo_o | output | N_NODES | Per-node chain enable outputs |
| int_no | output | 1 | Combined interrupt, active low |
| vec_o | output | 8 | Vector of the acknowledged node |
| vec_oe_o | output | 1 | Vector valid during an acknowledge |

## Verification
A node stuck pending or stuck under service would keep its own `ieo_o` bit and every lower bit low. That error shows at the ports in the first cycle after the edge that should have cleared it. A suspended node that wrongly obeyed a return would bring its enable line high one return too early, so the chain pattern after each return shows the nesting depth directly. A wrong priority choice or a wrong vector slice shows on `vec_o` one cycle after the acknowledge begins. A broken return decoder leaves the chain pattern unchanged after the 0x4D fetch.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned OPC_W     = 8;
  localparam logic [7:0]  OP_PREFIX = 8'hED;
  localparam logic [7:0]  OP_RET    = 8'h4D;
endpackage

// File: rtl/irq_reti_det.sv
module irq_reti_det #(
  parameter int unsigned      OPC_W  = irq_chain_pkg::OPC_W,
  parameter logic [OPC_W-1:0] PREFIX = irq_chain_pkg::OP_PREFIX,
  parameter logic [OPC_W-1:0] RET_OP = irq_chain_pkg::OP_RET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m1_i,
  input  logic             iorq_i,
  input  logic [OPC_W-1:0] data_i,
  output logic             reti_o
);
  logic m1_q, saw_pfx_q, fetch;

  assign fetch  = m1_i & ~iorq_i & ~m1_q;
  assign reti_o = fetch & saw_pfx_q & (data_i == RET_OP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q      <= 1'b0;
      saw_pfx_q <= 1'b0;
    end else begin
      m1_q <= m1_i;
      if (fetch) saw_pfx_q <= (data_i == PREFIX);
    end
  end

  // R7
  reti_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_o |=> !reti_o);
endmodule

// File: rtl/irq_node.sv
module irq_node (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iei_i,
  output logic ieo_o,
  input  logic req_i,
  input  logic m1_i,
  input  logic ack_start_i,
  input  logic reti_i,
  output logic grant_o,
  output logic int_no
);
  logic pend_q, svc_q;

  assign ieo_o   = iei_i & ~pend_q & ~svc_q;
  assign grant_o = iei_i & pend_q;
  assign int_no  = ~(iei_i & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else if (ack_start_i && grant_o) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b1;
    end else if (reti_i && svc_q && iei_i) begin
      svc_q  <= 1'b0;
    end else if (!m1_i && req_i && !svc_q) begin
      pend_q <= 1'b1;
    end
  end

  // R4
  pend_svc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && svc_q));
  // R4
  ack_to_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start_i && grant_o) |=> (svc_q && !pend_q));
  // R8
  suspended_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && svc_q && !iei_i) |=> svc_q);
  // R9
  frozen_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned VEC_W   = irq_chain_pkg::VEC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     m1_i,
  input  logic                     iorq_i,
  input  logic [N_NODES-1:0]       grant_i,
  input  logic [N_NODES*VEC_W-1:0] vec_i,
  output logic                     ack_start_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     vec_oe_o
);
  logic ack, ack_q, oe_q;
  logic [VEC_W-1:0] vec_q, vec_sel;

  assign ack         = m1_i & iorq_i;
  assign ack_start_o = ack & ~ack_q;

  always_comb begin
    vec_sel = '0;
    for (int k = 0; k < int'(N_NODES); k++)
      if (grant_i[k]) vec_sel = vec_sel | vec_i[k*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack;
      if (ack_start_o) begin
        oe_q  <= |grant_i;
        vec_q <= vec_sel;
      end else if (!ack) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign vec_o    = vec_q;
  assign vec_oe_o = oe_q & ack;

  // R5
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));
  // R4
  vec_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start_o && (|grant_i)) |=> (vec_oe_o || !(m1_i && iorq_i)));
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned VEC_W   = irq_chain_pkg::VEC_W,
  parameter int unsigned OPC_W   = irq_chain_pkg::OPC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     m1_i,
  input  logic                     iorq_i,
  input  logic [OPC_W-1:0]         data_i,
  input  logic                     iei_i,
  input  logic [N_NODES-1:0]       req_i,
  input  logic [N_NODES*VEC_W-1:0] vec_i,
  output logic [N_NODES-1:0]       ieo_o,
  output logic                     int_no,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     vec_oe_o
);
  logic [N_NODES:0]   en_chain;
  logic [N_NODES-1:0] grant, node_int_n;
  logic               ack_start, reti;

  assign en_chain[0] = iei_i;

  irq_reti_det #(.OPC_W(OPC_W)) u_reti (
    .clk_i, .rst_ni, .m1_i, .iorq_i, .data_i, .reti_o(reti)
  );

  for (genvar g = 0; g < N_NODES; g++) begin : g_node
    irq_node u_node (
      .clk_i, .rst_ni,
      .iei_i      (en_chain[g]),
      .ieo_o      (en_chain[g+1]),
      .req_i      (req_i[g]),
      .m1_i,
      .ack_start_i(ack_start),
      .reti_i     (reti),
      .grant_o    (grant[g]),
      .int_no     (node_int_n[g])
    );
  end

  irq_ack_ctl #(.N_NODES(N_NODES), .VEC_W(VEC_W)) u_ack (
    .clk_i, .rst_ni, .m1_i, .iorq_i,
    .grant_i    (grant),
    .vec_i,
    .ack_start_o(ack_start),
    .vec_o,
    .vec_oe_o
  );

  assign ieo_o  = en_chain[N_NODES:1];
  assign int_no = &node_int_n;

  // R2
  chain_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iei_i |-> (ieo_o == '0));
endmodule

// File: tb/sim_irq_chain_ctrl.sv
module sim_irq_chain_ctrl;
  localparam time CLK_P = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       m1_i = 1'b0, iorq_i = 1'b0, iei_i = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [3:0] req_i = 4'h0;
  logic [31:0] vec_i = {8'h46, 8'h44, 8'h42, 8'h40};
  logic [3:0] ieo_o;
  logic       int_no, vec_oe_o;
  logic [7:0] vec_o;

  irq_chain_ctrl u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  typedef struct {
    string      tag;
    logic [3:0] ieo;
    logic       int_n;
    logic       oe;
    logic [7:0] vec;
  } item_t;

  item_t q[$];
  event  exp_ev;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;

  // monitor: pops and compares
  initial forever begin
    @(exp_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (ieo_o !== it.ieo || int_no !== it.int_n || vec_oe_o !== it.oe ||
          (it.oe && vec_o !== it.vec)) begin
        n_bad++;
        $display("FAIL %s: got ieo=%b int_n=%b oe=%b vec=%h, exp ieo=%b int_n=%b oe=%b vec=%h",
                 it.tag, ieo_o, int_no, vec_oe_o, vec_o, it.ieo, it.int_n, it.oe, it.vec);
      end
    end
  end

  task automatic tick(input logic m1, input logic iorq, input logic [7:0] d,
                      input logic [3:0] rq);
    m1_i = m1; iorq_i = iorq; data_i = d; req_i = rq;
    @(posedge clk_i); #2;
  endtask

  task automatic expect_st(input string tag, input logic [3:0] ieo, input logic in_n,
                           input logic oe, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.ieo = ieo; it.int_n = in_n; it.oe = oe; it.vec = v;
    q.push_back(it);
    -> exp_ev;
    #1;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 8'h00, 4'h0);
  endtask

  task automatic ret_pair();
    tick(1'b1, 1'b0, 8'hED, 4'h0);
    idle();
    tick(1'b1, 1'b0, 8'h4D, 4'h0);
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) idle();
    expect_st("R1 in reset", 4'b1111, 1'b1, 1'b0, 8'h00);
    rst_ni = 1'b1;
    idle();
    expect_st("R1 after reset", 4'b1111, 1'b1, 1'b0, 8'h00);

    iei_i = 1'b0; #1;
    expect_st("R2 head blocked", 4'b0000, 1'b1, 1'b0, 8'h00);
    iei_i = 1'b1;

    tick(1'b0, 1'b0, 8'h00, 4'b0100);
    expect_st("R3 node2 pending", 4'b0011, 1'b0, 1'b0, 8'h00);
    idle();
    expect_st("R3 pending held", 4'b0011, 1'b0, 1'b0, 8'h00);

    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R4 ack node2", 4'b0011, 1'b1, 1'b1, 8'h44);
    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R4 vector held", 4'b0011, 1'b1, 1'b1, 8'h44);
    idle();
    expect_st("R4 ack end", 4'b0011, 1'b1, 1'b0, 8'h00);

    tick(1'b0, 1'b0, 8'h00, 4'b0010);
    expect_st("R6 node1 preempt request", 4'b0001, 1'b0, 1'b0, 8'h00);
    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R6 ack node1 over node2", 4'b0001, 1'b1, 1'b1, 8'h42);
    idle();

    ret_pair();
    expect_st("R8 first return, node2 resumed", 4'b0011, 1'b1, 1'b0, 8'h00);

    tick(1'b1, 1'b0, 8'hED, 4'h0);
    idle();
    tick(1'b1, 1'b0, 8'h00, 4'h0);
    idle();
    tick(1'b1, 1'b0, 8'h4D, 4'h0);
    idle();
    expect_st("R7 cancelled pair ignored", 4'b0011, 1'b1, 1'b0, 8'h00);

    ret_pair();
    expect_st("R8 second return clears", 4'b1111, 1'b1, 1'b0, 8'h00);

    tick(1'b0, 1'b0, 8'h00, 4'b1010);
    expect_st("R5 two pending", 4'b0001, 1'b0, 1'b0, 8'h00);
    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R5 node1 wins", 4'b0001, 1'b1, 1'b1, 8'h42);
    idle();
    ret_pair();
    expect_st("R5 node3 now visible", 4'b0111, 1'b0, 1'b0, 8'h00);
    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R5 ack node3", 4'b0111, 1'b1, 1'b1, 8'h46);
    idle();
    ret_pair();
    expect_st("R8 chain restored", 4'b1111, 1'b1, 1'b0, 8'h00);

    tick(1'b1, 1'b0, 8'h00, 4'b0001);
    expect_st("R9 req during fetch", 4'b1111, 1'b1, 1'b0, 8'h00);
    tick(1'b1, 1'b0, 8'h00, 4'b0001);
    expect_st("R9 req still frozen", 4'b1111, 1'b1, 1'b0, 8'h00);
    idle();
    expect_st("R9 nothing captured", 4'b1111, 1'b1, 1'b0, 8'h00);

    tick(1'b0, 1'b0, 8'h00, 4'b0001);
    expect_st("R3 node0 pending", 4'b0000, 1'b0, 1'b0, 8'h00);
    iei_i = 1'b0; #1;
    expect_st("R2 blocked pending no int", 4'b0000, 1'b1, 1'b0, 8'h00);
    iei_i = 1'b1; #1;
    tick(1'b1, 1'b1, 8'h00, 4'h0);
    expect_st("R4 ack node0", 4'b0000, 1'b1, 1'b1, 8'h40);
    idle();
    ret_pair();
    expect_st("R8 node0 done", 4'b1111, 1'b1, 1'b0, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      summary();
      $finish;
    end
  end
endmodule